// File: doc/BRIEF.md
# Filtered External Event Counter

This block counts transitions on an asynchronous input pin. The pin is first brought into the system clock domain by a two-stage synchroniser. It is then sampled once every eight system clocks, and the filtered level changes only when two successive samples agree on a new value. Because of this, glitches shorter than one sample interval never reach the counter. Each change of the filtered level is a rising or a falling edge. A programmable edge selector decides which of these edges advance a 16-bit counter.

A 16-bit compare value sets the count period. When an accepted edge arrives while the counter equals the compare value, the counter returns to zero and the interrupt output pulses high for one system clock. A compare value of zero is illegal, and while it is loaded the counter never moves. The compare value and the edge selector are loaded through write-enable ports. A run-enable input holds the counter at zero while it is low.

Top module: `evt_filter_counter`

## Requirements
- R1: After reset, `count` is 0, `irq` is low, the compare value is 16'hFFFF and the edge select is rising (2'b01).
- R2: With edge select 2'b01, each accepted rising edge of the filtered pin level increments `count` by one, and falling edges are not counted.
- R3: With edge select 2'b00, only accepted falling edges increment `count`.
- R4: With edge select 2'b11, both accepted rising and accepted falling edges increment `count`.
- R5: Edge select 2'b10 is reserved, and with it `count` does not change for any pin activity.
- R6: The pin is sampled once every 8 system clocks, and the filtered level changes only when two successive samples agree. A pulse shorter than 8 clocks is never counted.
- R7: When an accepted edge arrives while `count` equals the compare value, `count` becomes 0 on that clock edge and `irq` is high for exactly one clock.
- R8: While the compare value is 0, `count` never changes and `irq` stays low.
- R9: While `runEn` is low, `count` is 0 from the next clock, and counting restarts from zero when `runEn` returns high.
- R10: A compare write takes effect from the next clock. If `count` is already above the new value, it keeps counting upward (wrapping through 16'hFFFF to 0) with no interrupt and no clear.
- R11: A steady pin change is counted on the 11th to 18th rising clock edge after the change, depending on prescaler phase, and `count` changes at no other time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| runEn | input | 1 | Counter run enable; low holds count at zero |
| evtPin | input | 1 | Asynchronous external event input |
| cmpWrEn | input | 1 | Load strobe for the compare value |
| cmpWrData | input | 16 | New compare value |
| edgeSelWrEn | input | 1 | Load strobe for the edge select |
| edgeSelWrData | input | 2 | Edge select: 00 falling, 01 rising, 10 reserved, 11 both |
| count | output | 16 | Current event count |
| irq | output | 1 | One-clock interrupt pulse on compare match |

## Verification
The bench drives the pin in four kinds of pattern:
- Wide square pulses under each edge-select code. These separate rising, falling, both and reserved counting.
- Narrow pulses of three clocks. These confirm that the two-sample filter rejects them rather than passing them as single edges.
- A sequence with a small compare value, which shows the clear-and-pulse behaviour and the one-clock interrupt width.
- A compare rewritten below the current count, which shows that the counter keeps climbing instead of clearing.

A behavioural model in the bench covers the remaining timing. It tracks the synchroniser, the prescaler phase and the filter, and is compared with `count` and `irq` on every clock. This pins down the exact cycle in which each edge lands.

// File: rtl/evt_filter_pkg.sv
package evt_filter_pkg;

  typedef enum logic [1:0] {
    SEL_FALL = 2'b00,
    SEL_RISE = 2'b01,
    SEL_RSVD = 2'b10,
    SEL_BOTH = 2'b11
  } edgeSel_e;

  typedef struct packed {
    logic tick;
    logic riseStb;
    logic fallStb;
  } evtStrobe_t;

endpackage

// File: rtl/evt_filter_ctrl.sv
module evt_filter_ctrl #(
  parameter int SYNC_STAGES = 2,
  parameter int PRESC_LOG2  = 3
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic                      evtPin,
  output evt_filter_pkg::evtStrobe_t stb
);
  logic [SYNC_STAGES-1:0] syncReg;
  logic [PRESC_LOG2-1:0]  prescCnt;
  logic                   syncLvl;
  logic                   sampLvl;
  logic                   filtLvl;
  logic                   tick;
  logic                   levelChange;

  assign syncLvl = syncReg[SYNC_STAGES-1];
  assign tick    = &prescCnt;

  // Two successive samples agree on a level that differs from the filtered one.
  assign levelChange = tick && (syncLvl == sampLvl) && (syncLvl != filtLvl);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncReg  <= '0;
      prescCnt <= '0;
      sampLvl  <= 1'b0;
      filtLvl  <= 1'b0;
    end else begin
      syncReg  <= {syncReg[SYNC_STAGES-2:0], evtPin};
      prescCnt <= prescCnt + 1'b1;
      if (tick) sampLvl <= syncLvl;
      if (levelChange) filtLvl <= syncLvl;
    end
  end

  always_comb begin
    stb.tick    = tick;
    stb.riseStb = levelChange && syncLvl;
    stb.fallStb = levelChange && !syncLvl;
  end

  assert_filter_on_tick_R6: assert property (@(posedge clk) disable iff (!rstN)
    (filtLvl != $past(filtLvl)) |-> $past(tick));

  assert_strobe_exclusive_R4: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({stb.riseStb, stb.fallStb}));

endmodule

// File: rtl/evt_count_dp.sv
module evt_count_dp #(
  parameter int CNT_W = 16
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       runEn,
  input  evt_filter_pkg::evtStrobe_t stb,
  input  logic                       cmpWrEn,
  input  logic [CNT_W-1:0]           cmpWrData,
  input  logic                       edgeSelWrEn,
  input  logic [1:0]                 edgeSelWrData,
  output logic [CNT_W-1:0]           count,
  output logic                       irq
);
  import evt_filter_pkg::*;

  logic [CNT_W-1:0] cntReg;
  logic [CNT_W-1:0] cmpReg;
  edgeSel_e         selReg;
  logic             irqReg;
  logic             edgeHit;
  logic             cmpLegal;
  logic             atMatch;

  always_comb begin
    unique case (selReg)
      SEL_FALL: edgeHit = stb.fallStb;
      SEL_RISE: edgeHit = stb.riseStb;
      SEL_BOTH: edgeHit = stb.riseStb || stb.fallStb;
      default:  edgeHit = 1'b0;
    endcase
  end

  assign cmpLegal = |cmpReg;
  assign atMatch  = (cntReg == cmpReg);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cntReg <= '0;
      cmpReg <= '1;
      selReg <= SEL_RISE;
      irqReg <= 1'b0;
    end else begin
      irqReg <= 1'b0;
      if (!runEn) begin
        cntReg <= '0;
      end else if (edgeHit && cmpLegal) begin
        if (atMatch) begin
          cntReg <= '0;
          irqReg <= 1'b1;
        end else begin
          cntReg <= cntReg + 1'b1;
        end
      end
      if (cmpWrEn)     cmpReg <= cmpWrData;
      if (edgeSelWrEn) selReg <= edgeSel_e'(edgeSelWrData);
    end
  end

  assign count = cntReg;
  assign irq   = irqReg;

  assert_stop_clears_R9: assert property (@(posedge clk) disable iff (!rstN)
    !runEn |=> (count == '0));

  assert_irq_single_R7: assert property (@(posedge clk) disable iff (!rstN)
    irq |=> !irq);

  assert_irq_zero_count_R7: assert property (@(posedge clk) disable iff (!rstN)
    irq |-> (count == '0));

  assert_zero_cmp_hold_R8: assert property (@(posedge clk) disable iff (!rstN)
    (runEn && cmpReg == '0) |=> (count == $past(count)));

  assert_edge_on_tick_R11: assert property (@(posedge clk) disable iff (!rstN)
    (stb.riseStb || stb.fallStb) |-> stb.tick);

endmodule

// File: rtl/evt_filter_counter.sv
module evt_filter_counter #(
  parameter int CNT_W       = 16,
  parameter int SYNC_STAGES = 2,
  parameter int PRESC_LOG2  = 3
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             runEn,
  input  logic             evtPin,
  input  logic             cmpWrEn,
  input  logic [CNT_W-1:0] cmpWrData,
  input  logic             edgeSelWrEn,
  input  logic [1:0]       edgeSelWrData,
  output logic [CNT_W-1:0] count,
  output logic             irq
);
  evt_filter_pkg::evtStrobe_t stb;

  evt_filter_ctrl #(
    .SYNC_STAGES(SYNC_STAGES),
    .PRESC_LOG2 (PRESC_LOG2)
  ) u_ctrl (
    .clk   (clk),
    .rstN  (rstN),
    .evtPin(evtPin),
    .stb   (stb)
  );

  evt_count_dp #(
    .CNT_W(CNT_W)
  ) u_dp (
    .clk          (clk),
    .rstN         (rstN),
    .runEn        (runEn),
    .stb          (stb),
    .cmpWrEn      (cmpWrEn),
    .cmpWrData    (cmpWrData),
    .edgeSelWrEn  (edgeSelWrEn),
    .edgeSelWrData(edgeSelWrData),
    .count        (count),
    .irq          (irq)
  );

endmodule

// File: tb/evt_filter_counter_bench.sv
module evt_filter_counter_bench;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        runEn = 1'b0;
  logic        evtPin = 1'b0;
  logic        cmpWrEn = 1'b0;
  logic [15:0] cmpWrData = '0;
  logic        edgeSelWrEn = 1'b0;
  logic [1:0]  edgeSelWrData = '0;
  logic [15:0] count;
  logic        irq;

  int total = 0;
  int bad = 0;
  int irqSeen = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  evt_filter_counter u_evt_filter_counter (
    .clk(clk), .rstN(rstN), .runEn(runEn), .evtPin(evtPin),
    .cmpWrEn(cmpWrEn), .cmpWrData(cmpWrData),
    .edgeSelWrEn(edgeSelWrEn), .edgeSelWrData(edgeSelWrData),
    .count(count), .irq(irq)
  );

  // Behavioural reference model
  bit pipe[$];
  int phase, mSamp, mFilt, mCnt, mIrq, mCmp, mSel;

  task automatic modelReset();
    pipe = {1'b0, 1'b0};
    phase = 0; mSamp = 0; mFilt = 0; mCnt = 0; mIrq = 0;
    mCmp = 16'hFFFF; mSel = 1;
  endtask

  initial modelReset();

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      modelReset();
    end else begin
      int cur, rise, fall, hit;
      bit tick;
      cur = pipe[0];
      void'(pipe.pop_front());
      pipe.push_back(evtPin);
      tick = (phase == 7);
      phase = (phase + 1) % 8;
      rise = 0; fall = 0;
      if (tick) begin
        if (cur == mSamp && cur != mFilt) begin
          if (cur == 1) rise = 1; else fall = 1;
          mFilt = cur;
        end
        mSamp = cur;
      end
      case (mSel)
        0: hit = fall;
        1: hit = rise;
        3: hit = rise | fall;
        default: hit = 0;
      endcase
      mIrq = 0;
      if (!runEn) mCnt = 0;
      else if (hit != 0 && mCmp != 0) begin
        if (mCnt == mCmp) begin mCnt = 0; mIrq = 1; end
        else mCnt = (mCnt + 1) % 65536;
      end
      if (cmpWrEn) mCmp = cmpWrData;
      if (edgeSelWrEn) mSel = edgeSelWrData;
    end
  end

  // Cycle-by-cycle comparison, away from the active edge
  always @(negedge clk) begin
    if (rstN && !finished) begin
      total++;
      if (count !== 16'(mCnt) || irq !== 1'(mIrq)) begin
        bad++;
        $display("FAIL R11 cycle model: count=%0d irq=%0b expected count=%0d irq=%0d",
                 count, irq, mCnt, mIrq);
      end
      if (irq === 1'b1) irqSeen++;
    end
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic writeCmp(input logic [15:0] v);
    cmpWrData = v; cmpWrEn = 1'b1;
    @(negedge clk); cmpWrEn = 1'b0;
  endtask

  task automatic writeSel(input logic [1:0] v);
    edgeSelWrData = v; edgeSelWrEn = 1'b1;
    @(negedge clk); edgeSelWrEn = 1'b0;
  endtask

  task automatic pulses(input int n, input int hi, input int lo);
    for (int i = 0; i < n; i++) begin
      evtPin = 1'b1;
      repeat (hi) @(negedge clk);
      evtPin = 1'b0;
      repeat (lo) @(negedge clk);
    end
    repeat (30) @(negedge clk);
  endtask

  task automatic restart();
    runEn = 1'b0;
    repeat (3) @(negedge clk);
    runEn = 1'b1;
    irqSeen = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check(count == 0, "R1 reset count", count, 0);
    check(irq == 1'b0, "R1 reset irq", irq, 0);

    runEn = 1'b1;
    writeCmp(16'd1000);
    pulses(5, 40, 40);
    check(count == 5, "R2 rising count", count, 5);

    runEn = 1'b0;
    @(negedge clk); @(negedge clk);
    check(count == 0, "R9 stop clears", count, 0);
    runEn = 1'b1;

    writeSel(2'b00);
    pulses(3, 40, 40);
    check(count == 3, "R3 falling count", count, 3);

    restart();
    writeSel(2'b11);
    pulses(3, 40, 40);
    check(count == 6, "R4 both edges count", count, 6);

    restart();
    writeSel(2'b10);
    pulses(3, 40, 40);
    check(count == 0, "R5 reserved no count", count, 0);

    restart();
    writeSel(2'b01);
    pulses(10, 3, 40);
    check(count == 0, "R6 glitches rejected", count, 0);
    pulses(2, 40, 40);
    check(count == 2, "R6 wide pulses pass", count, 2);

    restart();
    writeCmp(16'd3);
    pulses(4, 40, 40);
    check(count == 0, "R7 clear on match", count, 0);
    check(irqSeen == 1, "R7 single irq", irqSeen, 1);
    pulses(3, 40, 40);
    check(count == 3, "R7 counts after clear", count, 3);

    restart();
    writeCmp(16'd0);
    pulses(4, 40, 40);
    check(count == 0, "R8 zero compare holds", count, 0);
    check(irqSeen == 0, "R8 zero compare no irq", irqSeen, 0);

    restart();
    writeCmp(16'd1000);
    pulses(5, 40, 40);
    writeCmp(16'd2);
    pulses(2, 40, 40);
    check(count == 7, "R10 above compare climbs", count, 7);
    check(irqSeen == 0, "R10 no irq above compare", irqSeen, 0);

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      total++; bad++;
      $display("FAIL R11 watchdog expired: actual=%0d expected=%0d", 1, 0);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule